// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command engine of a byte-addressed parallel NOR flash that follows the classic program/erase command set. A host reaches it over a plain synchronous memory port: one write strobe, one read strobe, a byte address, a write word, an access-size code and a registered read word. Writes are interpreted as commands or command operands. A small internal write-cycle counter tracks multi-write sequences: single-word program, sector erase with confirm, buffered write with a host-supplied word count, and lock/unlock. The engine keeps an 8-bit status byte and drives an on-chip byte array. Every program or erase finishes in the cycle of its final write.

Reads are served from one of four views: array data, status, identifier codes, or the query table that describes the part's geometry. A read-only input makes programs and erases fail into the status byte without touching the array. A big-endian input selects the byte order of multi-byte array accesses. Any write sequence the engine does not recognise silently returns it to array-read mode.

The port has no back-pressure. A write is taken in the cycle its strobe is high, and a read is answered exactly one cycle after its strobe. The host should not assert both strobes in the same cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80 and every array byte reads 0xFF.
- R2: In array-read mode, `size_i` selects 1, 2 or 4 bytes (codes 0, 1, 2; code 3 acts as 4) starting at `addr_i`. With `big_end_i` low the byte at `addr_i` sits in bits 7:0. With `big_end_i` high it sits in the most significant byte of the access. Unused upper bits read zero.
- R3: A first write whose low byte is 0x10 or 0x40, followed by a data write, stores the data at the second write's address in the R2 byte order and sets status bit 7. Reads then return status until the mode changes.
- R4: While `ro_i` is high, a program or buffered-write data write sets status bit 4 and a confirmed erase sets status bit 5. The array is left unchanged in both cases.
- R5: Command 0x20 followed by 0xD0 fills the whole sector holding the second write's address with 0xFF and sets bit 7. The sector is `SECTOR_BYTES` long and aligned to its own size. Command 0x20 followed by 0xFF, or by any other value, erases nothing and returns to array-read mode.
- R6: Command 0x50 clears the status byte to 0x00 and returns to array-read mode. Status error bits are otherwise sticky.
- R7: In status mode (command 0x70, or any program, erase, lock or buffered-write sequence), a read puts the status byte in bits 7:0 and repeats it at the base byte of each further `DEV_BYTES`-wide device lane that fits inside the access.
- R8: Command 0xE8 sets bit 7. The next write's data, masked to `8*DEV_BYTES` bits, becomes a count N. The following N+1 writes each store one word. The write after them must be 0xD0, which sets bit 7 and stays in status mode. Any other value returns to array-read mode.
- R9: Command 0x60 followed by any second write returns to array-read mode with the array unchanged.
- R10: After command 0x90, a read with index `addr_i >> log2(BANK_BYTES)` returns, in each device lane of the access, the maker code at index 0, the part code at index 1 and zero at any other index.
- R11: After command 0x98, a read returns the query byte at index `addr_i >> log2(BANK_BYTES)`, zero-extended, in each device lane. Indexes 0x10..0x12 hold 0x51, 0x52, 0x59. Index 0x27 holds log2 of one device's byte size. Index 0x2A holds 0x0B (0x08 for a one-byte bank). Index 0x2D holds the per-device sector count minus one, and index 0x2F holds `SECTOR_BYTES >> 8`. Indexes past the table read zero.
- R12: An unrecognised first command byte returns the block to array-read mode and leaves the status byte unchanged.
- R13: `rvalid_o` is high exactly in the cycle after each cycle in which `rd_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ro_i | input | 1 | Device is read-only; program and erase fail |
| big_end_i | input | 1 | Byte order of multi-byte array accesses |
| wr_en_i | input | 1 | Write strobe (command or operand) |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access size code: 0=1, 1=2, 2/3=4 bytes |
| wdata_i | input | 8*BANK_BYTES | Write word |
| rdata_o | output | 8*BANK_BYTES | Read word, valid with rvalid_o |
| rvalid_o | output | 1 | Read answer valid |

## Verification
The sequencer is driven through each write sequence with both well-formed and malformed second and confirm writes. This shows that a completed operation stays in status mode while a broken one falls back to array reads. Array reads are tried at all three sizes and in both byte orders at unaligned addresses, which tells a lane swap apart from an address offset. Buffered writes use a count word with bits above the device width set, which catches a missing mask. The same sequences repeated with the read-only input high show whether the error bit matches the failed operation and whether the array stays untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_BUFWR = 2'd2,
    OP_LOCK  = 2'd3
  } op_e;

  localparam logic [7:0] C_PROG_A  = 8'h10;
  localparam logic [7:0] C_PROG_B  = 8'h40;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_BUFWR   = 8'hE8;
  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_CONFIRM = 8'hD0;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;

  function automatic int unsigned lanes_of(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int DEV_BYTES = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ro_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rmode_e            mode_o,
  output logic [7:0]        status_o,
  output logic              prog_o,
  output logic              erase_o
);

  localparam int CNT_W = 8 * DEV_BYTES;

  logic [1:0]       wcyc_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  rmode_e           mode_q;
  logic [7:0]       stat_q;
  logic [7:0]       cbyte;

  assign cbyte    = wdata_i[7:0];
  assign mode_o   = mode_q;
  assign status_o = stat_q;

  always_comb begin
    prog_o  = 1'b0;
    erase_o = 1'b0;
    if (wr_en_i && !ro_i) begin
      prog_o  = (wcyc_q == 2'd1 && op_q == OP_PROG) ||
                (wcyc_q == 2'd2 && op_q == OP_BUFWR);
      erase_o = (wcyc_q == 2'd1 && op_q == OP_ERASE && cbyte == C_CONFIRM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcyc_q <= 2'd0;
      op_q   <= OP_PROG;
      cnt_q  <= '0;
      mode_q <= RM_ARRAY;
      stat_q <= 8'h80;
    end else if (wr_en_i) begin
      case (wcyc_q)
        2'd0: begin
          case (cbyte)
            C_PROG_A, C_PROG_B: begin
              op_q <= OP_PROG;  wcyc_q <= 2'd1; mode_q <= RM_STATUS;
            end
            C_ERASE: begin
              op_q <= OP_ERASE; wcyc_q <= 2'd1; mode_q <= RM_STATUS;
            end
            C_LOCK: begin
              op_q <= OP_LOCK;  wcyc_q <= 2'd1; mode_q <= RM_STATUS;
            end
            C_BUFWR: begin
              op_q <= OP_BUFWR; wcyc_q <= 2'd1; mode_q <= RM_STATUS;
              stat_q[ST_READY] <= 1'b1;
            end
            C_CLR: begin
              stat_q <= 8'h00;
              mode_q <= RM_ARRAY;
            end
            C_STAT:  mode_q <= RM_STATUS;
            C_IDENT: mode_q <= RM_IDENT;
            C_QUERY: mode_q <= RM_QUERY;
            default: mode_q <= RM_ARRAY;
          endcase
        end
        2'd1: begin
          case (op_q)
            OP_PROG: begin
              if (ro_i) stat_q[ST_PROG_ERR] <= 1'b1;
              stat_q[ST_READY] <= 1'b1;
              wcyc_q <= 2'd0;
            end
            OP_ERASE: begin
              wcyc_q <= 2'd0;
              if (cbyte == C_CONFIRM) begin
                if (ro_i) stat_q[ST_ERASE_ERR] <= 1'b1;
                stat_q[ST_READY] <= 1'b1;
              end else begin
                mode_q <= RM_ARRAY;
              end
            end
            OP_BUFWR: begin
              cnt_q  <= wdata_i[CNT_W-1:0];
              wcyc_q <= 2'd2;
            end
            default: begin
              wcyc_q <= 2'd0;
              mode_q <= RM_ARRAY;
            end
          endcase
        end
        2'd2: begin
          if (ro_i) stat_q[ST_PROG_ERR] <= 1'b1;
          if (cnt_q == '0) wcyc_q <= 2'd3;
          else             cnt_q  <= cnt_q - CNT_W'(1);
        end
        default: begin
          wcyc_q <= 2'd0;
          if (cbyte == C_CONFIRM) stat_q[ST_READY] <= 1'b1;
          else                    mode_q <= RM_ARRAY;
        end
      endcase
    end
  end

  a_r3_prog_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wcyc_q == 2'd1 && op_q == OP_PROG) |=> stat_q[ST_READY]);

  a_r4_ro_prog_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && ro_i && wcyc_q == 2'd1 && op_q == OP_PROG) |=> stat_q[ST_PROG_ERR]);

  a_r5_erase_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wcyc_q == 2'd1 && op_q == OP_ERASE && cbyte != C_CONFIRM)
    |=> (mode_q == RM_ARRAY && wcyc_q == 2'd0));

  a_r6_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wcyc_q == 2'd0 && cbyte == C_CLR) |=> (stat_q == 8'h00 && mode_q == RM_ARRAY));

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wcyc_q == 2'd2 && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r12_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wcyc_q == 2'd0 && cbyte != C_CLR && cbyte != C_BUFWR) |=> $stable(stat_q));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W       = 10,
  parameter int BANK_BYTES   = 4,
  parameter int SECTOR_BYTES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_i,
  input  logic                    erase_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              sz_i,
  input  logic                    be_i,
  input  logic [8*BANK_BYTES-1:0] wdata_i,
  output logic [8*BANK_BYTES-1:0] rword_o
);
  import flash_seq_pkg::*;

  localparam int DEPTH   = 2 ** ADDR_W;
  localparam int SECT_LG = $clog2(SECTOR_BYTES);

  logic [7:0] mem_q [DEPTH];
  int unsigned n;

  always_comb begin
    n = lanes_of(sz_i);
    if (n > BANK_BYTES) n = BANK_BYTES;
  end

  always_comb begin
    rword_o = '0;
    for (int i = 0; i < BANK_BYTES; i++) begin
      if (i < int'(n)) begin
        if (be_i) rword_o[8*(int'(n)-1-i) +: 8] = mem_q[addr_i + ADDR_W'(i)];
        else      rword_o[8*i +: 8]             = mem_q[addr_i + ADDR_W'(i)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= 8'hFF;
    end else if (erase_i) begin
      for (int j = 0; j < DEPTH; j++) begin
        if ((ADDR_W'(j) >> SECT_LG) == (addr_i >> SECT_LG)) mem_q[j] <= 8'hFF;
      end
    end else if (prog_i) begin
      for (int i = 0; i < BANK_BYTES; i++) begin
        if (i < int'(n)) begin
          if (be_i) mem_q[addr_i + ADDR_W'(i)] <= wdata_i[8*(int'(n)-1-i) +: 8];
          else      mem_q[addr_i + ADDR_W'(i)] <= wdata_i[8*i +: 8];
        end
      end
    end
  end

  a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_i && erase_i));

endmodule

// File: rtl/flash_ident.sv
module flash_ident
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          BANK_BYTES   = 4,
  parameter int          DEV_BYTES    = 2,
  parameter int          SECTOR_BYTES = 256,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] PART_CODE    = 16'h0018
) (
  input  rmode_e                  mode_i,
  input  logic [7:0]              status_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              sz_i,
  output logic [8*BANK_BYTES-1:0] word_o
);

  localparam int MEM_BYTES   = 2 ** ADDR_W;
  localparam int BANK_LG     = $clog2(BANK_BYTES);
  localparam int NDEV        = BANK_BYTES / DEV_BYTES;
  localparam int BLK_PER_DEV = (MEM_BYTES / SECTOR_BYTES) / NDEV;
  localparam int DEV_LEN_LG  = $clog2(SECTOR_BYTES * BLK_PER_DEV);
  localparam int BUF_LG      = (BANK_BYTES == 1) ? 8 : 11;
  localparam int LW          = 8 * DEV_BYTES;

  function automatic logic [7:0] cfi_byte(input int unsigned i);
    case (i)
      32'h10: return 8'h51;
      32'h11: return 8'h52;
      32'h12: return 8'h59;
      32'h13: return 8'h01;
      32'h15: return 8'h31;
      32'h1B: return 8'h45;
      32'h1C: return 8'h55;
      32'h1F: return 8'h07;
      32'h20: return 8'h07;
      32'h21: return 8'h0A;
      32'h23: return 8'h04;
      32'h24: return 8'h04;
      32'h25: return 8'h04;
      32'h27: return 8'(DEV_LEN_LG);
      32'h28: return 8'h02;
      32'h2A: return 8'(BUF_LG);
      32'h2C: return 8'h01;
      32'h2D: return 8'(BLK_PER_DEV - 1);
      32'h2E: return 8'((BLK_PER_DEV - 1) >> 8);
      32'h2F: return 8'(SECTOR_BYTES >> 8);
      32'h30: return 8'(SECTOR_BYTES >> 16);
      32'h31: return 8'h50;
      32'h32: return 8'h52;
      32'h33: return 8'h49;
      32'h34: return 8'h31;
      32'h35: return 8'h30;
      32'h3F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  int unsigned n;
  int unsigned idx;
  logic [LW-1:0] lane_val;

  always_comb begin
    n = lanes_of(sz_i);
    if (n > BANK_BYTES) n = BANK_BYTES;
    idx = int'(addr_i >> BANK_LG);
    lane_val = '0;
    if (mode_i == RM_IDENT) begin
      if (idx[7:0] == 8'd0)      lane_val = LW'(MFR_CODE);
      else if (idx[7:0] == 8'd1) lane_val = LW'(PART_CODE);
    end else begin
      lane_val = LW'(cfi_byte(idx));
    end
  end

  always_comb begin
    word_o = '0;
    case (mode_i)
      RM_STATUS: begin
        word_o[7:0] = status_i;
        for (int k = 1; k < NDEV; k++) begin
          if ((k + 1) * DEV_BYTES <= int'(n)) word_o[8*k*DEV_BYTES +: 8] = status_i;
        end
      end
      RM_IDENT, RM_QUERY: begin
        for (int k = 0; k < NDEV; k++) begin
          if (k * DEV_BYTES < int'(n)) word_o[k*LW +: LW] = lane_val;
        end
        for (int b = 0; b < BANK_BYTES; b++) begin
          if (b >= int'(n)) word_o[8*b +: 8] = 8'h00;
        end
      end
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          BANK_BYTES   = 4,
  parameter int          DEV_BYTES    = 2,
  parameter int          SECTOR_BYTES = 256,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] PART_CODE    = 16'h0018
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ro_i,
  input  logic                    big_end_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [8*BANK_BYTES-1:0] wdata_i,
  output logic [8*BANK_BYTES-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DATA_W = 8 * BANK_BYTES;

  rmode_e            mode;
  logic [7:0]        status;
  logic              prog, erase;
  logic [DATA_W-1:0] array_word, ident_word;

  flash_cmd_fsm #(.DEV_BYTES(DEV_BYTES), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ro_i(ro_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .mode_o(mode), .status_o(status), .prog_o(prog), .erase_o(erase)
  );

  flash_array #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_i(prog), .erase_i(erase), .addr_i(addr_i),
    .sz_i(size_i), .be_i(big_end_i), .wdata_i(wdata_i), .rword_o(array_word)
  );

  flash_ident #(
    .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .MFR_CODE(MFR_CODE), .PART_CODE(PART_CODE)
  ) u_ident (
    .mode_i(mode), .status_i(status), .addr_i(addr_i), .sz_i(size_i), .word_o(ident_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= (mode == RM_ARRAY) ? array_word : ident_word;
    end
  end

  a_r13_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);

  a_r13_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rvalid_o);

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int SECT = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ro = 1'b0, be = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]  sz = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  byte unsigned m_mem [DEPTH];
  int m_st, m_mode, m_wc, m_op, m_cnt;  // mode: 0 array,1 status,2 ident,3 query

  always #10 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ro_i(ro), .big_end_i(be), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .size_i(sz), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic int q_exp(input int i);
    case (i)
      'h10: return 'h51; 'h11: return 'h52; 'h12: return 'h59;
      'h27: return 9;    'h2A: return 'h0B; 'h2D: return 1; 'h2F: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic m_store(input int a, input int n, input logic [31:0] d);
    for (int i = 0; i < n; i++)
      m_mem[(a + i) % DEPTH] = be ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
  endtask

  task automatic m_write(input int a, input int n, input logic [31:0] d);
    int c = d[7:0];
    case (m_wc)
      0: case (c)
        'h10, 'h40: begin m_op = 0; m_wc = 1; m_mode = 1; end
        'h20: begin m_op = 1; m_wc = 1; m_mode = 1; end
        'h60: begin m_op = 3; m_wc = 1; m_mode = 1; end
        'hE8: begin m_op = 2; m_wc = 1; m_mode = 1; m_st |= 'h80; end
        'h50: begin m_st = 0; m_mode = 0; end
        'h70: m_mode = 1;
        'h90: m_mode = 2;
        'h98: m_mode = 3;
        default: m_mode = 0;
      endcase
      1: begin
        if (m_op == 0) begin
          if (ro) m_st |= 'h10; else m_store(a, n, d);
          m_st |= 'h80; m_wc = 0;
        end else if (m_op == 1) begin
          m_wc = 0;
          if (c == 'hD0) begin
            if (ro) m_st |= 'h20;
            else for (int j = (a / SECT) * SECT; j < (a / SECT) * SECT + SECT; j++) m_mem[j] = 'hFF;
            m_st |= 'h80;
          end else m_mode = 0;
        end else if (m_op == 2) begin
          m_cnt = d & 'hFFFF; m_wc = 2;
        end else begin
          m_wc = 0; m_mode = 0;
        end
      end
      2: begin
        if (ro) m_st |= 'h10; else m_store(a, n, d);
        if (m_cnt == 0) m_wc = 3; else m_cnt--;
      end
      default: begin
        m_wc = 0;
        if (c == 'hD0) m_st |= 'h80; else m_mode = 0;
      end
    endcase
  endtask

  function automatic logic [31:0] m_read(input int a, input int n);
    logic [31:0] r = 0;
    int idx = a >> 2;
    int lane;
    case (m_mode)
      0: for (int i = 0; i < n; i++)
           if (be) r[8*(n-1-i) +: 8] = m_mem[(a + i) % DEPTH];
           else    r[8*i +: 8]       = m_mem[(a + i) % DEPTH];
      1: begin r[7:0] = m_st[7:0]; if (n == 4) r[23:16] = m_st[7:0]; end
      default: begin
        if (m_mode == 2) lane = (idx % 256 == 0) ? 'h0089 : (idx % 256 == 1) ? 'h0018 : 0;
        else lane = q_exp(idx);
        r[15:0] = lane[15:0];
        if (n == 4) r[31:16] = lane[15:0];
        if (n == 1) r[31:8] = 0;
      end
    endcase
    return r;
  endfunction

  task automatic bw(input int a, input logic [1:0] s, input logic [31:0] d);
    m_write(a, nb(s), d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); sz = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic br(input int a, input logic [1:0] s, input string req);
    logic [31:0] exp = m_read(a, nb(s));
    @(negedge clk);
    rd = 1'b1; addr = AW'(a); sz = s;
    @(negedge clk);
    rd = 1'b0;
    checks++;
    if (!rvalid || rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h: actual=%h valid=%b expected=%h", req, a, rdata, rvalid, exp);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int j = 0; j < DEPTH; j++) m_mem[j] = 'hFF;
    m_st = 'h80; m_mode = 0; m_wc = 0; m_op = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    br('h000, 2'd2, "R1");
    br('h3FD, 2'd0, "R1");
    bw(0, 2'd2, 'h70);
    br(0, 2'd2, "R1 R7");
    br(0, 2'd1, "R7");
    // R3 program, R2 lane order
    bw(0, 2'd2, 'h40);
    bw('h10, 2'd2, 'h11223344);
    br(0, 2'd2, "R3");
    bw(0, 2'd2, 'hFF);
    br('h10, 2'd2, "R2");
    br('h11, 2'd0, "R2");
    br('h12, 2'd1, "R2");
    be = 1'b1;
    br('h10, 2'd2, "R2");
    br('h11, 2'd1, "R2");
    bw(0, 2'd2, 'h10);
    bw('h21, 2'd1, 'h0000AABB);
    bw(0, 2'd2, 'hFF);
    br('h20, 2'd2, "R3");
    be = 1'b0;
    br('h21, 2'd1, "R3");
    // R5 erase and cancel
    bw(0, 2'd2, 'h40);
    bw('h180, 2'd2, 'hCAFE0001);
    bw(0, 2'd2, 'h40);
    bw('h204, 2'd2, 'h12345678);
    bw(0, 2'd2, 'h20);
    bw('h1A7, 2'd2, 'hD0);
    br(0, 2'd2, "R5");
    bw(0, 2'd2, 'hFF);
    br('h180, 2'd2, "R5");
    br('h10, 2'd2, "R5");
    bw(0, 2'd2, 'h20);
    bw('h204, 2'd2, 'hFF);
    br('h204, 2'd2, "R5");
    bw(0, 2'd2, 'h20);
    bw('h204, 2'd2, 'h33);
    br('h204, 2'd2, "R5");
    // R4 read-only failures, R6 clear
    ro = 1'b1;
    bw(0, 2'd2, 'h40);
    bw('h204, 2'd2, 'h0);
    br(0, 2'd2, "R4");
    bw(0, 2'd2, 'h20);
    bw('h204, 2'd2, 'hD0);
    br(0, 2'd2, "R4");
    bw(0, 2'd2, 'h44);
    br(0, 2'd2, "R12");
    bw(0, 2'd2, 'hFF);
    br('h204, 2'd2, "R4");
    bw(0, 2'd2, 'hE8);
    bw('h300, 2'd2, 'h0);
    bw('h300, 2'd2, 'h0BAD0BAD);
    bw('h300, 2'd2, 'hD0);
    br(0, 2'd2, "R4");
    ro = 1'b0;
    bw(0, 2'd2, 'h50);
    br('h204, 2'd2, "R6");
    br('h300, 2'd2, "R4");
    bw(0, 2'd2, 'h70);
    br(0, 2'd2, "R6");
    // R8 buffered write, count masked to 16 bits
    bw(0, 2'd2, 'hE8);
    br(0, 2'd2, "R8");
    bw('h40, 2'd2, 'h00030001);
    bw('h40, 2'd2, 'hA1A2A3A4);
    bw('h44, 2'd2, 'hB1B2B3B4);
    bw('h48, 2'd2, 'hD0);
    br(0, 2'd2, "R8");
    bw(0, 2'd2, 'hFF);
    br('h40, 2'd2, "R8");
    br('h44, 2'd2, "R8");
    br('h48, 2'd2, "R8");
    bw(0, 2'd2, 'hE8);
    bw('h80, 2'd2, 'h0);
    bw('h80, 2'd2, 'h55667788);
    bw('h80, 2'd2, 'h12);
    br('h80, 2'd2, "R8");
    // R9 lock
    bw(0, 2'd2, 'h60);
    bw('h80, 2'd2, 'h01);
    br('h80, 2'd2, "R9");
    bw(0, 2'd2, 'h60);
    bw('h80, 2'd2, 'hD0);
    br('h80, 2'd2, "R9");
    bw(0, 2'd2, 'h60);
    bw('h80, 2'd2, 'h77);
    br('h80, 2'd2, "R9");
    // R10 identifiers
    bw(0, 2'd2, 'h90);
    br(0, 2'd2, "R10");
    br(4, 2'd2, "R10");
    br(8, 2'd2, "R10");
    br(4, 2'd0, "R10");
    // R11 query table
    bw(0, 2'd2, 'h98);
    br('h10 * 4, 2'd2, "R11");
    br('h11 * 4, 2'd2, "R11");
    br('h12 * 4, 2'd1, "R11");
    br('h27 * 4, 2'd2, "R11");
    br('h2A * 4, 2'd2, "R11");
    br('h2D * 4, 2'd2, "R11");
    br('h2F * 4, 2'd2, "R11");
    br('h60 * 4, 2'd2, "R11");
    // R12 unknown command
    bw(0, 2'd2, 'h33);
    br('h40, 2'd2, "R12");
    // R13 read with no strobe leaves valid low
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R13: actual=%b expected=0", rvalid);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule